// File: doc/BRIEF.md
# Link Training Sequencer

This block is the control sequencer that brings a DisplayPort-style main link from idle to a trained state. It does no analog work and does not decode reply bytes itself. It sends abstract register-write and register-read requests to an auxiliary-channel client. It drives a small set of local PHY commands, times the required settling pauses, and reacts to pass/fail flags supplied by a separate status evaluator. That evaluator also supplies the next drive setting.

Training runs in two phases. The first phase is clock recovery, which uses training pattern 1. The second phase is channel equalisation, which uses training pattern 2. Each phase has its own pause, its own status poll and its own abort rules. A clock-recovery failure is recorded but does not stop the run: equalisation is still attempted. At the end the sequencer always switches the sink back to no pattern and reports two separate failure flags. Pauses are measured in ticks of a one-microsecond strobe, so a faster strobe compresses time in test.

Top module: `lt_train_seq`

## Requirements
- R1: After reset the block is idle: `req_valid`, `busy`, `done`, `cr_failed` and `eq_failed` are 0, `phy_pattern` is 0 and `wait_us` is 0.
- R2: On `start`, if `sink_rev` is 0x11 or above, the first request writes the byte 0x01 to address 0x600 (sink power-up). Below 0x11 that request is left out and the first request is the pattern write of R3.
- R3: Two writes follow, in this order. First, 0x00 is written to address 0x102 (pattern off). Second, a two-byte write goes to address 0x100. Data byte 0 is the rate code: 0x06 when `rate_hi` is 0, 0x0a when it is 1. Data byte 1 is the lane count, with bit 7 set when `sink_rev` is 0x11 or above.
- R4: Next, 0x00 is written to address 0x107. Then `phy_start` pulses for one cycle and `phy_pattern` becomes 1. Then the block waits 400 ticks of `tick_us`.
- R5: After the 400-tick wait, 0x01 is written to address 0x102. Then the drive setting is written to address 0x103, with length equal to the lane count and every data byte equal to the current drive byte. The drive byte is 0x00 at the start of a run.
- R6: Each clock-recovery iteration waits 100 ticks and then issues a 6-byte read at address 0x202. If `ev_cr_ok` is set when that read completes, the block moves to equalisation.
- R7: Clock recovery aborts, and sets `cr_failed`, when a status read completes with `ev_max_swing` set and `ev_cr_ok` clear.
- R8: Clock recovery aborts, and sets `cr_failed`, on the fifth consecutive status read in which the swing field (bits 1:0) of `ev_adj_drive` equals the swing field of the current drive byte.
- R9: Equalisation writes 0x02 to address 0x102 and sets `phy_pattern` to 2. Each iteration then waits 400 ticks and issues a 6-byte read at 0x202. `ev_eq_ok` on that read ends the phase successfully.
- R10: Equalisation gives up, and sets `eq_failed`, on the seventh consecutive status read without `ev_eq_ok`.
- R11: A status read that completes with `xact_err` ends the current phase at once as a failure of that phase.
- R12: Every run ends the same way, pass or fail. The block writes 0x00 to address 0x102, pulses `phy_complete` once and returns `phy_pattern` to 0. It then holds `done` high with the flags of R7–R11. A clock-recovery failure does not prevent the equalisation phase from running.
- R13: A request is held stable until `xact_done`. When a phase continues to a further iteration, `ev_adj_drive` from the completing read becomes the new drive byte. That byte appears on `phy_drive` and in the next drive write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a training run (accepted when idle or done) |
| sink_rev | input | 8 | Sink capability revision |
| rate_hi | input | 1 | 1 selects the 2.7 GHz rate code, 0 the 1.62 GHz code |
| lane_cnt | input | 3 | Active lanes: 1, 2 or 4 |
| tick_us | input | 1 | One-microsecond strobe |
| req_valid | output | 1 | Request to the auxiliary-channel client |
| req_write | output | 1 | 1 write, 0 read |
| req_addr | output | 16 | Sink register address |
| req_len | output | 3 | Byte count |
| req_data | output | 32 | Write bytes, byte 0 in bits 7:0 |
| xact_done | input | 1 | Client finished the current request |
| xact_err | input | 1 | Qualifies `xact_done`: transaction failed |
| ev_cr_ok | input | 1 | Evaluator: all active lanes recovered clock |
| ev_eq_ok | input | 1 | Evaluator: equalisation, symbol lock and alignment met |
| ev_max_swing | input | 1 | Evaluator: every active lane reports maximum swing |
| ev_adj_drive | input | 8 | Evaluator: next drive byte (swing in bits 1:0) |
| phy_start | output | 1 | One-cycle local training-start command |
| phy_complete | output | 1 | One-cycle local training-complete command |
| phy_pattern | output | 2 | Local pattern select: 0 off, 1 recovery, 2 equalisation |
| phy_drive | output | 8 | Current drive byte |
| wait_us | output | 12 | Remaining microseconds of the current pause |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| cr_failed | output | 1 | Clock-recovery phase failed |
| eq_failed | output | 1 | Equalisation phase failed |

## Verification
The hardest condition to reach is the same-swing abort. It requires five consecutive completed clock-recovery reads whose requested swing matches the drive already in use, with no recovery success and no max-swing flag in between. The bench's client model plays the evaluator. Per read it answers with a scripted adjust byte and scripted flags, and it indexes those answers by the local pattern in force, so recovery reads and equalisation reads are scripted separately. The tick strobe runs at half the clock rate, so the 400 µs pauses stay short. The tick counts between the requests are compared against the pause lengths.

// File: rtl/lt_pkg.sv
package lt_pkg;

    localparam logic [15:0] A_POWER   = 16'h0600;
    localparam logic [15:0] A_PATTERN = 16'h0102;
    localparam logic [15:0] A_LINKCFG = 16'h0100;
    localparam logic [15:0] A_SPREAD  = 16'h0107;
    localparam logic [15:0] A_DRIVE   = 16'h0103;
    localparam logic [15:0] A_STATUS  = 16'h0202;

    localparam logic [7:0] RATE_CODE_LO = 8'h06;
    localparam logic [7:0] RATE_CODE_HI = 8'h0a;
    localparam logic [7:0] REV_ENHANCED = 8'h11;
    localparam logic [7:0] POWER_ON     = 8'h01;
    localparam logic [2:0] STATUS_BYTES = 3'd6;

    typedef enum logic [1:0] {
        PAT_OFF = 2'd0,
        PAT_CR  = 2'd1,
        PAT_EQ  = 2'd2
    } lt_pat_e;

    typedef enum logic [4:0] {
        S_IDLE, S_PWR, S_PAT0, S_CFG, S_SPREAD, S_PHY_START, S_SETUP_WAIT,
        S_PAT1, S_CR_DRV, S_CR_WAIT, S_CR_RD,
        S_EQ_PAT2, S_EQ_WAIT, S_EQ_RD, S_EQ_DRV,
        S_END_PAT0, S_END_PHY, S_DONE
    } lt_state_e;

    typedef struct packed {
        logic        valid;
        logic        write;
        logic [15:0] addr;
        logic [2:0]  len;
        logic [31:0] data;
    } lt_req_t;

    function automatic logic [7:0] lane_cfg_byte(input logic [2:0] lanes, input logic enh);
        return {enh, 4'b0000, lanes};
    endfunction

    function automatic logic is_wait_state(input lt_state_e s);
        return (s == S_SETUP_WAIT) || (s == S_CR_WAIT) || (s == S_EQ_WAIT);
    endfunction

endpackage

// File: rtl/lt_wait_timer.sv
module lt_wait_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic         expired
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/lt_loop_ctr.sv
module lt_loop_ctr #(
    parameter int MAX = 5,
    localparam int W = $clog2(MAX + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = W'(MAX);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && cnt != TOP)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/lt_req_build.sv
module lt_req_build
    import lt_pkg::*;
(
    input  lt_state_e  state,
    input  logic       enh,
    input  logic       rate_hi,
    input  logic [2:0] lanes,
    input  logic [7:0] drive,
    output lt_req_t    req
);
    always_comb begin
        req = '0;
        case (state)
            S_PWR: begin
                req.valid = 1'b1; req.write = 1'b1; req.addr = A_POWER;
                req.len = 3'd1; req.data = {24'd0, POWER_ON};
            end
            S_PAT0, S_END_PAT0: begin
                req.valid = 1'b1; req.write = 1'b1; req.addr = A_PATTERN;
                req.len = 3'd1; req.data = {30'd0, PAT_OFF};
            end
            S_CFG: begin
                req.valid = 1'b1; req.write = 1'b1; req.addr = A_LINKCFG;
                req.len = 3'd2;
                req.data = {16'd0, lane_cfg_byte(lanes, enh),
                            rate_hi ? RATE_CODE_HI : RATE_CODE_LO};
            end
            S_SPREAD: begin
                req.valid = 1'b1; req.write = 1'b1; req.addr = A_SPREAD;
                req.len = 3'd1; req.data = '0;
            end
            S_PAT1: begin
                req.valid = 1'b1; req.write = 1'b1; req.addr = A_PATTERN;
                req.len = 3'd1; req.data = {30'd0, PAT_CR};
            end
            S_EQ_PAT2: begin
                req.valid = 1'b1; req.write = 1'b1; req.addr = A_PATTERN;
                req.len = 3'd1; req.data = {30'd0, PAT_EQ};
            end
            S_CR_DRV, S_EQ_DRV: begin
                req.valid = 1'b1; req.write = 1'b1; req.addr = A_DRIVE;
                req.len = lanes; req.data = {4{drive}};
            end
            S_CR_RD, S_EQ_RD: begin
                req.valid = 1'b1; req.write = 1'b0; req.addr = A_STATUS;
                req.len = STATUS_BYTES; req.data = '0;
            end
            default: req = '0;
        endcase
    end
endmodule

// File: rtl/lt_train_seq.sv
module lt_train_seq
    import lt_pkg::*;
#(
    parameter int WAIT_W       = 12,
    parameter int SETUP_US     = 400,
    parameter int CR_US        = 100,
    parameter int EQ_US        = 400,
    parameter int SWING_REPEAT = 5,
    parameter int EQ_RETRIES   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        sink_rev,
    input  logic              rate_hi,
    input  logic [2:0]        lane_cnt,
    input  logic              tick_us,
    output logic              req_valid,
    output logic              req_write,
    output logic [15:0]       req_addr,
    output logic [2:0]        req_len,
    output logic [31:0]       req_data,
    input  logic              xact_done,
    input  logic              xact_err,
    input  logic              ev_cr_ok,
    input  logic              ev_eq_ok,
    input  logic              ev_max_swing,
    input  logic [7:0]        ev_adj_drive,
    output logic              phy_start,
    output logic              phy_complete,
    output logic [1:0]        phy_pattern,
    output logic [7:0]        phy_drive,
    output logic [WAIT_W-1:0] wait_us,
    output logic              busy,
    output logic              done,
    output logic              cr_failed,
    output logic              eq_failed
);
    localparam int SW_W  = $clog2(SWING_REPEAT + 1);
    localparam int EQ_MX = EQ_RETRIES + 1;
    localparam int EQ_W  = $clog2(EQ_MX + 1);
    localparam logic [SW_W-1:0] SW_LAST = SW_W'(SWING_REPEAT - 1);
    localparam logic [EQ_W-1:0] EQ_LAST = EQ_W'(EQ_MX);

    lt_state_e   state, nxt;
    logic        enh_q, rate_q;
    logic [2:0]  lanes_q;
    logic [7:0]  drive_q;
    lt_pat_e     pat_q;
    lt_req_t     req;

    logic              wt_load, wt_expired;
    logic [WAIT_W-1:0] wt_val;
    logic [SW_W-1:0]   swing_cnt;
    logic [EQ_W-1:0]   eq_cnt;

    logic cr_rd_done, cr_continue, same_swing, swing_inc, swing_clr, swing_abort;
    logic eq_rd_done, eq_continue, eq_abort;
    logic cr_fail_set, eq_fail_set, take_adj, launch;

    // request formatting
    lt_req_build u_req (
        .state  (state),
        .enh    (enh_q),
        .rate_hi(rate_q),
        .lanes  (lanes_q),
        .drive  (drive_q),
        .req    (req)
    );

    // pause timer
    lt_wait_timer #(.W(WAIT_W)) u_wait (
        .clk     (clk),
        .rst     (rst),
        .load    (wt_load),
        .load_val(wt_val),
        .tick    (tick_us),
        .cnt     (wait_us),
        .expired (wt_expired)
    );

    // consecutive same-swing counter (recovery phase)
    lt_loop_ctr #(.MAX(SWING_REPEAT)) u_swing (
        .clk(clk), .rst(rst), .clr(swing_clr), .inc(swing_inc), .cnt(swing_cnt)
    );

    // unsuccessful-read counter (equalisation phase)
    lt_loop_ctr #(.MAX(EQ_MX)) u_eqtry (
        .clk(clk), .rst(rst), .clr(state == S_EQ_PAT2), .inc(eq_continue && !eq_abort),
        .cnt(eq_cnt)
    );

    assign launch      = start && (state == S_IDLE || state == S_DONE);
    assign same_swing  = (ev_adj_drive[1:0] == drive_q[1:0]);
    assign cr_rd_done  = (state == S_CR_RD) && xact_done;
    assign cr_continue = cr_rd_done && !xact_err && !ev_cr_ok && !ev_max_swing;
    assign swing_inc   = cr_continue && same_swing;
    assign swing_clr   = (state == S_PAT1) || (cr_continue && !same_swing);
    assign swing_abort = swing_inc && (swing_cnt == SW_LAST);
    assign eq_rd_done  = (state == S_EQ_RD) && xact_done;
    assign eq_continue = eq_rd_done && !xact_err && !ev_eq_ok;
    assign eq_abort    = eq_continue && (eq_cnt == EQ_LAST);
    assign cr_fail_set = (cr_rd_done && (xact_err || (!ev_cr_ok && ev_max_swing))) || swing_abort;
    assign eq_fail_set = (eq_rd_done && xact_err) || eq_abort;
    assign take_adj    = (cr_continue && !swing_abort) || (eq_continue && !eq_abort);

    always_comb begin
        nxt = state;
        case (state)
            S_IDLE, S_DONE: if (launch) nxt = (sink_rev >= REV_ENHANCED) ? S_PWR : S_PAT0;
            S_PWR:          if (xact_done) nxt = S_PAT0;
            S_PAT0:         if (xact_done) nxt = S_CFG;
            S_CFG:          if (xact_done) nxt = S_SPREAD;
            S_SPREAD:       if (xact_done) nxt = S_PHY_START;
            S_PHY_START:    nxt = S_SETUP_WAIT;
            S_SETUP_WAIT:   if (wt_expired) nxt = S_PAT1;
            S_PAT1:         if (xact_done) nxt = S_CR_DRV;
            S_CR_DRV:       if (xact_done) nxt = S_CR_WAIT;
            S_CR_WAIT:      if (wt_expired) nxt = S_CR_RD;
            S_CR_RD:        if (xact_done) nxt = (cr_continue && !swing_abort) ? S_CR_DRV : S_EQ_PAT2;
            S_EQ_PAT2:      if (xact_done) nxt = S_EQ_WAIT;
            S_EQ_WAIT:      if (wt_expired) nxt = S_EQ_RD;
            S_EQ_RD:        if (xact_done) nxt = (eq_continue && !eq_abort) ? S_EQ_DRV : S_END_PAT0;
            S_EQ_DRV:       if (xact_done) nxt = S_EQ_WAIT;
            S_END_PAT0:     if (xact_done) nxt = S_END_PHY;
            S_END_PHY:      nxt = S_DONE;
            default:        nxt = S_IDLE;
        endcase
    end

    always_comb begin
        wt_load = is_wait_state(nxt) && (nxt != state);
        case (nxt)
            S_SETUP_WAIT: wt_val = WAIT_W'(SETUP_US);
            S_CR_WAIT:    wt_val = WAIT_W'(CR_US);
            default:      wt_val = WAIT_W'(EQ_US);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            enh_q     <= 1'b0;
            rate_q    <= 1'b0;
            lanes_q   <= 3'd0;
            drive_q   <= 8'd0;
            pat_q     <= PAT_OFF;
            cr_failed <= 1'b0;
            eq_failed <= 1'b0;
        end else begin
            state <= nxt;
            if (launch) begin
                enh_q     <= (sink_rev >= REV_ENHANCED);
                rate_q    <= rate_hi;
                lanes_q   <= lane_cnt;
                drive_q   <= 8'd0;
                cr_failed <= 1'b0;
                eq_failed <= 1'b0;
            end else begin
                if (take_adj)    drive_q   <= ev_adj_drive;
                if (cr_fail_set) cr_failed <= 1'b1;
                if (eq_fail_set) eq_failed <= 1'b1;
            end
            if (state == S_PHY_START)
                pat_q <= PAT_CR;
            else if (state == S_EQ_PAT2 && xact_done)
                pat_q <= PAT_EQ;
            else if (state == S_END_PHY)
                pat_q <= PAT_OFF;
        end
    end

    assign req_valid    = req.valid;
    assign req_write    = req.write;
    assign req_addr     = req.addr;
    assign req_len      = req.len;
    assign req_data     = req.data;
    assign phy_start    = (state == S_PHY_START);
    assign phy_complete = (state == S_END_PHY);
    assign phy_pattern  = pat_q;
    assign phy_drive    = drive_q;
    assign busy         = (state != S_IDLE) && (state != S_DONE);
    assign done         = (state == S_DONE);
endmodule

// File: rtl/lt_train_chk.sv
module lt_train_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [15:0] req_addr,
    input logic        xact_done,
    input logic        busy,
    input logic        done,
    input logic        phy_start,
    input logic        phy_complete,
    input logic [1:0]  phy_pattern,
    input logic        waiting
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !req_valid);

    a_r13_req_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !xact_done) |=> (req_valid && $stable(req_addr) && $stable(req_write)));

    a_r4_start_sel_pat1: assert property (@(posedge clk) disable iff (rst)
        phy_start |=> (phy_pattern == 2'd1));

    a_r6_pause_no_req: assert property (@(posedge clk) disable iff (rst)
        waiting |-> !req_valid);

    a_r12_done_after_complete: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(phy_complete));

    a_r12_done_pattern_off: assert property (@(posedge clk) disable iff (rst)
        done |-> (phy_pattern == 2'd0 && !busy));
endmodule

bind lt_train_seq lt_train_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .xact_done   (xact_done),
    .busy        (busy),
    .done        (done),
    .phy_start   (phy_start),
    .phy_complete(phy_complete),
    .phy_pattern (phy_pattern),
    .waiting     (|wait_us)
);

// File: tb/lt_train_seq_tb_top.sv
`timescale 1ns/1ps
module lt_train_seq_tb_top;
    logic        clk, rst, start, rate_hi, tick_us;
    logic [7:0]  sink_rev;
    logic [2:0]  lane_cnt;
    logic        req_valid, req_write;
    logic [15:0] req_addr;
    logic [2:0]  req_len;
    logic [31:0] req_data;
    logic        xact_done, xact_err;
    logic        ev_cr_ok, ev_eq_ok, ev_max_swing;
    logic [7:0]  ev_adj_drive;
    logic        phy_start, phy_complete;
    logic [1:0]  phy_pattern;
    logic [7:0]  phy_drive;
    logic [11:0] wait_us;
    logic        busy, done, cr_failed, eq_failed;

    lt_train_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .sink_rev(sink_rev), .rate_hi(rate_hi),
        .lane_cnt(lane_cnt), .tick_us(tick_us),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_len(req_len), .req_data(req_data),
        .xact_done(xact_done), .xact_err(xact_err),
        .ev_cr_ok(ev_cr_ok), .ev_eq_ok(ev_eq_ok), .ev_max_swing(ev_max_swing),
        .ev_adj_drive(ev_adj_drive),
        .phy_start(phy_start), .phy_complete(phy_complete), .phy_pattern(phy_pattern),
        .phy_drive(phy_drive), .wait_us(wait_us), .busy(busy), .done(done),
        .cr_failed(cr_failed), .eq_failed(eq_failed)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    initial begin
        tick_us = 1'b0;
        forever begin
            @(negedge clk);
            tick_us = ~tick_us;
        end
    end

    int cyc = 0, tick_ctr = 0, n_pstart = 0, n_pcomp = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tick_us)      tick_ctr <= tick_ctr + 1;
        if (phy_start)    n_pstart <= n_pstart + 1;
        if (phy_complete) n_pcomp  <= n_pcomp + 1;
    end

    int n_chk = 0, n_fail = 0;

    // request log written only by the client model
    logic        l_wr   [256];
    logic [15:0] l_addr [256];
    logic [2:0]  l_len  [256];
    logic [31:0] l_data [256];
    int          l_tick [256];
    logic [1:0]  l_pat  [256];
    int n_log = 0, cr_n = 0, eq_n = 0;

    // scenario script, written by tasks only
    int cr_base = 0, eq_base = 0;
    int cfg_cr_ok_at = 0, cfg_max_at = 0, cfg_cr_err_at = 0;
    int cfg_eq_ok_at = 0, cfg_eq_err_at = 0;
    logic [7:0] cfg_adj = 8'h00;

    // client + evaluator model
    initial begin
        xact_done = 1'b0; xact_err = 1'b0;
        ev_cr_ok = 1'b0; ev_eq_ok = 1'b0; ev_max_swing = 1'b0; ev_adj_drive = 8'h00;
        forever begin
            @(negedge clk);
            if (req_valid && !rst) begin
                int idx;
                logic rd_cr, rd_eq;
                idx = n_log % 256;
                l_wr[idx] = req_write; l_addr[idx] = req_addr; l_len[idx] = req_len;
                l_data[idx] = req_data; l_tick[idx] = tick_ctr; l_pat[idx] = phy_pattern;
                rd_cr = !req_write && phy_pattern == 2'd1;
                rd_eq = !req_write && phy_pattern == 2'd2;
                if (rd_cr) cr_n = cr_n + 1;
                if (rd_eq) eq_n = eq_n + 1;
                n_log = n_log + 1;
                repeat (2) @(negedge clk);
                if (rd_cr) begin
                    ev_cr_ok     = ((cr_n - cr_base) == cfg_cr_ok_at);
                    ev_max_swing = ((cr_n - cr_base) == cfg_max_at);
                    xact_err     = ((cr_n - cr_base) == cfg_cr_err_at);
                    ev_adj_drive = cfg_adj;
                end
                if (rd_eq) begin
                    ev_eq_ok     = ((eq_n - eq_base) == cfg_eq_ok_at);
                    xact_err     = ((eq_n - eq_base) == cfg_eq_err_at);
                    ev_adj_drive = cfg_adj;
                end
                xact_done = 1'b1;
                @(negedge clk);
                xact_done = 1'b0; xact_err = 1'b0;
                ev_cr_ok = 1'b0; ev_eq_ok = 1'b0; ev_max_swing = 1'b0; ev_adj_drive = 8'h00;
            end
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input string what, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    int base = 0, ps0 = 0, pc0 = 0;

    task automatic run_train(input logic [7:0] rev, input logic rhi, input logic [2:0] ln);
        base = n_log; cr_base = cr_n; eq_base = eq_n; ps0 = n_pstart; pc0 = n_pcomp;
        @(negedge clk);
        sink_rev = rev; rate_hi = rhi; lane_cnt = ln; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk_req(input string r, input int i, input logic wr, input logic [15:0] a,
                           input logic [2:0] len, input logic [31:0] d);
        int k;
        k = (base + i) % 256;
        chk(r, $sformatf("req %0d write", i), l_wr[k], wr);
        chk(r, $sformatf("req %0d addr", i), l_addr[k], a);
        chk(r, $sformatf("req %0d len", i), l_len[k], len);
        if (wr) chk(r, $sformatf("req %0d data", i), l_data[k], d);
    endtask

    function automatic int tick_gap(input int i, input int j);
        return l_tick[(base + j) % 256] - l_tick[(base + i) % 256];
    endfunction

    task automatic chk_ending(input string r, input logic crf, input logic eqf);
        int last;
        last = (n_log - 1) % 256;
        chk(r, "final addr", l_addr[last], 16'h0102);
        chk(r, "final data", l_data[last], 32'h0);
        chk(r, "phy_complete pulses", n_pcomp - pc0, 1);
        chk(r, "done", done, 1);
        chk(r, "phy_pattern", phy_pattern, 0);
        chk(r, "cr_failed", cr_failed, crf);
        chk(r, "eq_failed", eq_failed, eqf);
    endtask

    task automatic set_script(input int crok, input int mx, input int crerr,
                              input int eqok, input int eqerr, input logic [7:0] adj);
        cfg_cr_ok_at = crok; cfg_max_at = mx; cfg_cr_err_at = crerr;
        cfg_eq_ok_at = eqok; cfg_eq_err_at = eqerr; cfg_adj = adj;
    endtask

    task automatic t_reset;
        chk("R1", "req_valid", req_valid, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "phy_pattern", phy_pattern, 0);
        chk("R1", "wait_us", wait_us, 0);
        chk("R1", "cr/eq failed", {cr_failed, eq_failed}, 0);
    endtask

    // full success, new sink, high rate, four lanes
    task automatic t_happy;
        set_script(1, 0, 0, 1, 0, 8'h00);
        run_train(8'h12, 1'b1, 3'd4);
        chk("R2", "request count", n_log - base, 10);
        chk_req("R2", 0, 1, 16'h0600, 3'd1, 32'h01);
        chk_req("R3", 1, 1, 16'h0102, 3'd1, 32'h00);
        chk_req("R3", 2, 1, 16'h0100, 3'd2, 32'h840a);
        chk_req("R4", 3, 1, 16'h0107, 3'd1, 32'h00);
        chk("R4", "phy_start pulses", n_pstart - ps0, 1);
        chk_range("R4", "setup pause ticks", tick_gap(3, 4), 400, 406);
        chk_req("R5", 4, 1, 16'h0102, 3'd1, 32'h01);
        chk_req("R5", 5, 1, 16'h0103, 3'd4, 32'h0);
        chk("R4", "pattern during drive write", l_pat[(base + 5) % 256], 1);
        chk_req("R6", 6, 0, 16'h0202, 3'd6, 32'h0);
        chk_range("R6", "recovery pause ticks", tick_gap(5, 6), 100, 106);
        chk_req("R9", 7, 1, 16'h0102, 3'd1, 32'h02);
        chk_req("R9", 8, 0, 16'h0202, 3'd6, 32'h0);
        chk("R9", "pattern during eq read", l_pat[(base + 8) % 256], 2);
        chk_range("R9", "eq pause ticks", tick_gap(7, 8), 400, 406);
        chk_ending("R12", 1'b0, 1'b0);
    endtask

    // old sink, low rate, two lanes, eq passes on second read
    task automatic t_old_sink;
        set_script(1, 0, 0, 2, 0, 8'h09);
        run_train(8'h10, 1'b0, 3'd2);
        chk("R2", "request count old sink", n_log - base, 11);
        chk_req("R2", 0, 1, 16'h0102, 3'd1, 32'h00);
        chk_req("R3", 1, 1, 16'h0100, 3'd2, 32'h0206);
        chk_req("R5", 4, 1, 16'h0103, 3'd2, 32'h0);
        chk_req("R13", 8, 1, 16'h0103, 3'd2, 32'h09090909);
        chk("R13", "phy_drive", phy_drive, 8'h09);
        chk_req("R9", 9, 0, 16'h0202, 3'd6, 32'h0);
        chk_ending("R12", 1'b0, 1'b0);
    endtask

    task automatic t_same_swing;
        set_script(0, 0, 0, 1, 0, 8'h08);
        run_train(8'h11, 1'b1, 3'd1);
        chk("R8", "recovery reads", cr_n - cr_base, 5);
        chk("R12", "eq still run", eq_n - eq_base, 1);
        chk_ending("R8", 1'b1, 1'b0);
    endtask

    task automatic t_max_swing;
        set_script(0, 2, 0, 1, 0, 8'h01);
        run_train(8'h11, 1'b0, 3'd4);
        chk("R7", "recovery reads", cr_n - cr_base, 2);
        chk("R7", "eq reads", eq_n - eq_base, 1);
        chk_ending("R7", 1'b1, 1'b0);
    endtask

    task automatic t_eq_retry;
        set_script(1, 0, 0, 0, 0, 8'h00);
        run_train(8'h12, 1'b1, 3'd2);
        chk("R10", "eq reads", eq_n - eq_base, 7);
        chk_ending("R10", 1'b0, 1'b1);
    endtask

    task automatic t_read_err;
        set_script(0, 0, 2, 0, 1, 8'h00);
        run_train(8'h12, 1'b1, 3'd4);
        chk("R11", "recovery reads", cr_n - cr_base, 2);
        chk("R11", "eq reads", eq_n - eq_base, 1);
        chk_ending("R11", 1'b1, 1'b1);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        wait (cyc >= 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got cycle %0d expected completion", cyc);
        finish_run();
    end

    initial begin
        rst = 1'b1; start = 1'b0; sink_rev = 8'h00; rate_hi = 1'b0; lane_cnt = 3'd1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_happy();
        t_old_sink();
        t_same_swing();
        t_max_swing();
        t_eq_retry();
        t_read_err();
        finish_run();
    end
endmodule